// File: doc/BRIEF.md
# Chip-Select Window Decoder for Memory-Mapped Serial Flash

This block sits in front of a serial-flash controller and turns a flat, memory-mapped read window into a choice among three flash chip selects. Each select owns a segment register that holds an inclusive window expressed in coarse 8 MB units. An incoming bus address is compared against all three windows. The block returns a one-hot chip-select match and the byte offset of the address inside the matching device. It flags an address that falls in no window as a decode error.

A small register port lets software read and rewrite the segment registers and a per-select 4-byte address-mode control. The outer edges of the full window are fixed: the start of select 0 and the end of select 2 cannot be changed by software. When windows overlap, the lowest-numbered select wins. Requests use a valid/ready handshake, and every accepted request produces a registered response one cycle later.

Top module: `fwin_decoder`

## Requirements
- R1: After reset the segment registers read back 0x5F400000 (select 0, offset 0x30), 0x53500000 (select 1, offset 0x34) and 0x57540000 (select 2, offset 0x38), and the mode register (offset 0x04) reads 0.
- R2: Each segment register holds the window start unit in bits [23:16] and the last window unit (inclusive) in bits [31:24]. Bits [15:0] read as zero. A writable field reads back what was written. An access to an unmapped offset reads 0 and changes no register.
- R3: The start field of select 0 and the end field of select 2 are read-only and keep their reset values (0x40 and 0x57) whatever is written to them.
- R4: The mode register stores a per-select 4-byte-address enable in bit n for select n, and a companion bit in bit n+4. Every other bit reads 0. Output `addr4b_en[n]` follows bit n.
- R5: An address hits select n when bit 31 is 0 and address bits [30:23] lie between that select's start and end fields, inclusive.
- R6: A window whose end field is below its start field never matches.
- R7: When several windows match, only the lowest-numbered select is reported in `rsp_cs`.
- R8: `rsp_offset` equals the bus address minus the matching window's start field times 8 MB.
- R9: An accepted address that hits no window gives `rsp_err`=1 with `rsp_cs`=0 and `rsp_offset`=0.
- R10: `rsp_valid` rises in the cycle after a request is accepted and is low otherwise; `rsp_err` and `rsp_cs` are 0 while it is low. A request accepted on the same edge as a segment write is decoded with the contents from before that write.
- R11: `req_ready` is 0 while reset is held and is 1 from the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| addr4b_en | output | 3 | Per-select 4-byte address enable |
| req_valid | input | 1 | Decode request valid |
| req_ready | output | 1 | Decoder ready to accept |
| req_addr | input | 32 | Bus address to decode |
| rsp_valid | output | 1 | Decode response valid |
| rsp_cs | output | 3 | One-hot chip-select match |
| rsp_offset | output | 32 | Offset within the selected device |
| rsp_err | output | 1 | Address hit no window |

## Verification
Register read data is combinational, so the bench reads it a short delay after it sets the offset. Register writes and `addr4b_en` are observed in the low phase after the write edge. A decode response is due exactly one edge after the edge that accepts the request. The bench raises each request in a low phase and samples the response in the next low phase. One test drives a segment write and a request on the same edge, then checks that the response uses the old window and that the following request uses the new one.

// File: rtl/fwin_pkg.sv
package fwin_pkg;

    localparam int NSEL        = 3;
    localparam int ADDR_W      = 32;
    localparam int DATA_W      = 32;
    localparam int REG_AW      = 8;
    localparam int UNIT_LSB    = 23;
    localparam int FIELD_W     = 8;
    localparam int START_LSB   = 16;
    localparam int END_LSB     = START_LSB + FIELD_W;
    localparam int MODE_HI_LSB = 4;
    localparam int HI_W        = ADDR_W - UNIT_LSB;

    localparam logic [REG_AW-1:0] SEG_BASE_OFS = 8'h30;
    localparam logic [REG_AW-1:0] MODE_OFS     = 8'h04;

    typedef logic [FIELD_W-1:0] unit_t;

    // hi = last unit of window (inclusive), lo = first unit
    typedef struct packed {
        unit_t hi;
        unit_t lo;
    } seg_t;

    typedef struct packed {
        logic              valid;
        logic              err;
        logic [NSEL-1:0]   cs;
        logic [ADDR_W-1:0] ofs;
    } rsp_t;

    function automatic seg_t seg_default(input int idx);
        seg_t s;
        case (idx)
            0:       begin s.lo = 8'h40; s.hi = 8'h5F; end
            1:       begin s.lo = 8'h50; s.hi = 8'h53; end
            2:       begin s.lo = 8'h54; s.hi = 8'h57; end
            default: begin s.lo = 8'hFF; s.hi = 8'h00; end
        endcase
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] seg_pack(input seg_t s);
        return DATA_W'({s.hi, s.lo}) << START_LSB;
    endfunction

    function automatic logic [ADDR_W-1:0] unit_base(input unit_t u);
        return ADDR_W'(u) << UNIT_LSB;
    endfunction

endpackage

// File: rtl/fwin_regs.sv
module fwin_regs
    import fwin_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [REG_AW-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    output seg_t [NSEL-1:0]       seg_o,
    output logic [NSEL-1:0]       mode_en_o
);

    logic [NSEL-1:0] mode_lo_q;
    logic [NSEL-1:0] mode_hi_q;

    for (genvar i = 0; i < NSEL; i++) begin : g_seg
        localparam logic [REG_AW-1:0] OFS = SEG_BASE_OFS + REG_AW'(4 * i);
        localparam bit   START_RO = (i == 0);
        localparam bit   END_RO   = (i == NSEL - 1);
        localparam seg_t DFLT     = seg_default(i);

        seg_t q;
        logic sel;
        assign sel = wr_en && (addr == OFS);

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= DFLT;
            end else if (sel) begin
                if (!START_RO) q.lo <= wdata[START_LSB +: FIELD_W];
                if (!END_RO)   q.hi <= wdata[END_LSB +: FIELD_W];
            end
        end

        assign seg_o[i] = q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_lo_q <= '0;
            mode_hi_q <= '0;
        end else if (wr_en && addr == MODE_OFS) begin
            mode_lo_q <= wdata[NSEL-1:0];
            mode_hi_q <= wdata[MODE_HI_LSB +: NSEL];
        end
    end

    assign mode_en_o = mode_lo_q;

    always_comb begin
        rdata = '0;
        if (addr == MODE_OFS) begin
            rdata[NSEL-1:0]            = mode_lo_q;
            rdata[MODE_HI_LSB +: NSEL] = mode_hi_q;
        end
        for (int i = 0; i < NSEL; i++) begin
            if (addr == SEG_BASE_OFS + REG_AW'(4 * i)) rdata = seg_pack(seg_o[i]);
        end
    end

    logic unused_wdata;
    assign unused_wdata = ^{wdata[START_LSB-1:MODE_HI_LSB+NSEL], wdata[MODE_HI_LSB-1:NSEL]};

    // R3: fixed outer edges survive any write to their registers
    assert_start0_ro_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == SEG_BASE_OFS) |=> $stable(seg_o[0].lo));
    assert_endlast_ro_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == SEG_BASE_OFS + REG_AW'(4 * (NSEL - 1))) |=> $stable(seg_o[NSEL-1].hi));
    // R2: a write to an unmapped offset leaves the mode bits alone
    assert_mode_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == MODE_OFS) |=> $stable(mode_en_o));

endmodule

// File: rtl/fwin_match.sv
module fwin_match
    import fwin_pkg::*;
(
    input  seg_t              seg,
    input  logic [HI_W-1:0]   addr_hi,
    output logic              hit,
    output logic [ADDR_W-1:0] base
);

    unit_t unit;
    logic  above_lo;
    logic  below_hi;

    assign unit     = addr_hi[FIELD_W-1:0];
    assign above_lo = (unit >= seg.lo);
    assign below_hi = (unit <= seg.hi);
    assign hit      = !addr_hi[HI_W-1] && above_lo && below_hi;
    assign base     = unit_base(seg.lo);

endmodule

// File: rtl/fwin_select.sv
module fwin_select
    import fwin_pkg::*;
(
    input  logic [NSEL-1:0]             hit,
    input  logic [NSEL-1:0][ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0]           addr,
    output logic [NSEL-1:0]             cs,
    output logic                        err,
    output logic [ADDR_W-1:0]           ofs
);

    logic              found;
    logic [ADDR_W-1:0] pick_base;

    always_comb begin
        cs        = '0;
        found     = 1'b0;
        pick_base = '0;
        for (int i = 0; i < NSEL; i++) begin
            if (hit[i] && !found) begin
                cs[i]     = 1'b1;
                pick_base = base[i];
                found     = 1'b1;
            end
        end
        err = !found;
        ofs = found ? (addr - pick_base) : '0;
    end

endmodule

// File: rtl/fwin_decoder.sv
module fwin_decoder
    import fwin_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic [2:0]  addr4b_en,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_addr,
    output logic        rsp_valid,
    output logic [2:0]  rsp_cs,
    output logic [31:0] rsp_offset,
    output logic        rsp_err
);

    seg_t [NSEL-1:0]             seg_w;
    logic [NSEL-1:0]             hit_w;
    logic [NSEL-1:0][ADDR_W-1:0] base_w;
    logic [NSEL-1:0]             cs_w;
    logic                        err_w;
    logic [ADDR_W-1:0]           ofs_w;
    logic                        ready_q;
    logic                        accept;
    rsp_t                        rsp_q;

    fwin_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .seg_o     (seg_w),
        .mode_en_o (addr4b_en)
    );

    for (genvar i = 0; i < NSEL; i++) begin : g_win
        fwin_match u_match (
            .seg     (seg_w[i]),
            .addr_hi (req_addr[ADDR_W-1:UNIT_LSB]),
            .hit     (hit_w[i]),
            .base    (base_w[i])
        );

        // R6: an inverted window never shows up in the response
        assert_empty_win_R6: assert property (@(posedge clk) disable iff (rst)
            (accept && seg_w[i].hi < seg_w[i].lo) |=> !rsp_cs[i]);
    end

    fwin_select u_select (
        .hit  (hit_w),
        .base (base_w),
        .addr (req_addr),
        .cs   (cs_w),
        .err  (err_w),
        .ofs  (ofs_w)
    );

    assign accept = req_valid && ready_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q <= 1'b0;
            rsp_q   <= '0;
        end else begin
            ready_q     <= 1'b1;
            rsp_q.valid <= accept;
            rsp_q.cs    <= accept ? cs_w  : '0;
            rsp_q.err   <= accept ? err_w : 1'b0;
            rsp_q.ofs   <= accept ? ofs_w : '0;
        end
    end

    assign req_ready  = ready_q;
    assign rsp_valid  = rsp_q.valid;
    assign rsp_cs     = rsp_q.cs;
    assign rsp_err    = rsp_q.err;
    assign rsp_offset = rsp_q.ofs;

    assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid == $past(req_valid && req_ready));
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_err && rsp_cs == '0));
    assert_cs_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rsp_cs));
    assert_err_excl_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_err != (rsp_cs != '0)));
    assert_miss_zero_ofs_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> rsp_offset == '0);
    assert_ready_R11: assert property (@(posedge clk) disable iff (rst)
        !rst |=> req_ready);

endmodule

// File: tb/fwin_decoder_test.sv
module fwin_decoder_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [2:0]  addr4b_en;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        rsp_valid;
    logic [2:0]  rsp_cs;
    logic [31:0] rsp_offset;
    logic        rsp_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0] ms [3];
    logic [7:0] me [3];

    always #(CLK_PERIOD / 2) clk = ~clk;

    fwin_decoder uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .addr4b_en(addr4b_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_cs(rsp_cs), .rsp_offset(rsp_offset),
        .rsp_err(rsp_err)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, 64'(reg_rdata), 64'(exp));
    endtask

    function automatic logic [36:0] model(input logic [31:0] a);
        logic [7:0]  u;
        logic [36:0] r;
        u = a[30:23];
        r = {1'b1, 1'b1, 3'b000, 32'h0};
        if (!a[31]) begin
            for (int i = 2; i >= 0; i--) begin
                if (u >= ms[i] && u <= me[i])
                    r = {1'b1, 1'b0, 3'(1 << i), a - {1'b0, ms[i], 23'h0}};
            end
        end
        return r;
    endfunction

    function automatic logic [36:0] actual();
        return {rsp_valid, rsp_err, rsp_cs, rsp_offset};
    endfunction

    task automatic decode(input string tag, input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk(tag, 64'(actual()), 64'(model(a)));
    endtask

    task automatic sweep(input string tag);
        for (int u = 0; u < 256; u++) begin
            for (int b = 0; b < 2; b++) begin
                logic [22:0] low;
                case ((u * 3 + b) % 4)
                    0:       low = 23'h0;
                    1:       low = 23'h7FFFFF;
                    default: low = 23'(u * 32'h2F1B3 + b * 32'h511);
                endcase
                decode(tag, {1'(b), 8'(u), low});
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        ms[0] = 8'h40; me[0] = 8'h5F;
        ms[1] = 8'h50; me[1] = 8'h53;
        ms[2] = 8'h54; me[2] = 8'h57;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 ready low in reset", 64'(req_ready), 64'd0);
        chk("R10 no response in reset", 64'(actual()), 64'd0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R11 ready after reset", 64'(req_ready), 64'd1);

        // R1 reset contents
        reg_check("R1 seg0", 8'h30, 32'h5F40_0000);
        reg_check("R1 seg1", 8'h34, 32'h5350_0000);
        reg_check("R1 seg2", 8'h38, 32'h5754_0000);
        reg_check("R1 mode", 8'h04, 32'h0);
        chk("R1 addr4b_en", 64'(addr4b_en), 64'd0);

        // R4 mode register
        reg_write(8'h04, 32'hFFFF_FFFF);
        reg_check("R4 mode all ones", 8'h04, 32'h0000_0077);
        chk("R4 addr4b_en all", 64'(addr4b_en), 64'd7);
        reg_write(8'h04, 32'h0000_0022);
        reg_check("R4 mode select1 pair", 8'h04, 32'h0000_0022);
        chk("R4 addr4b_en select1", 64'(addr4b_en), 64'd2);

        // R2 unmapped offset is inert
        reg_write(8'h08, 32'hFFFF_FFFF);
        reg_check("R2 unmapped reads 0", 8'h08, 32'h0);
        reg_check("R2 seg0 untouched", 8'h30, 32'h5F40_0000);
        reg_check("R2 mode untouched", 8'h04, 32'h0000_0022);

        // Defaults sweep: hits, overlap priority, offsets, misses
        sweep("R5 R7 R8 R9 defaults");

        // R10 same-edge write: old contents decode, next request sees new
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h38; reg_wdata = 32'h0000_0000;
        req_valid = 1'b1; req_addr = 32'h1000_0000;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; req_valid = 1'b0;
        #1;
        chk("R10 same-edge uses old window", 64'(actual()), 64'({1'b1, 1'b1, 3'b000, 32'h0}));
        @(negedge clk);
        chk("R10 idle after one response", 64'(actual()), 64'd0);
        ms[2] = 8'h00;
        decode("R10 new window visible", 32'h1000_0000);
        reg_check("R3 seg2 end kept", 8'h38, 32'h5700_0000);

        // Config 2: select0 inverted (start fixed), select1 inverted
        reg_write(8'h30, 32'h3FAA_1234);
        reg_check("R3 R2 seg0 start kept", 8'h30, 32'h3F40_0000);
        me[0] = 8'h3F;
        reg_write(8'h34, 32'h1020_0000);
        reg_check("R2 seg1 readback", 8'h34, 32'h1020_0000);
        ms[1] = 8'h20; me[1] = 8'h10;
        sweep("R6 empty windows");

        // Config 3: nested overlaps
        reg_write(8'h30, 32'hFF00_0000);
        reg_check("R3 seg0 start kept again", 8'h30, 32'hFF40_0000);
        me[0] = 8'hFF;
        reg_write(8'h34, 32'h8030_0000);
        ms[1] = 8'h30; me[1] = 8'h80;
        reg_write(8'h38, 32'h12AB_0000);
        reg_check("R3 seg2 end ignores write", 8'h38, 32'h57AB_0000);
        ms[2] = 8'hAB;
        reg_write(8'h38, 32'h0000_0000);
        ms[2] = 8'h00;
        sweep("R7 R8 overlap priority");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule